// File: doc/BRIEF.md
# DDR SDRAM Refresh Command Sequencer

This block produces the command stream that refreshes a DDR SDRAM between normal accesses. The memory controller offers a refresh job on a valid/ready port. The job carries a bitmask of the banks that are still open and asks for either one or two refresh commands. Once the job is accepted, the sequencer closes any open rows. It uses a single-bank precharge when one bank is open and an all-bank precharge when several are open. It then waits out the precharge recovery window and issues AUTO REFRESH. After each AUTO REFRESH it keeps the bus quiet for the refresh cycle window. When the last window has passed it releases the bus, and the controller may then issue ACTIVE.

The timing windows are given as parameters in picoseconds, together with the clock period. They are converted into whole clock cycles when the design elaborates. The command pins, A10 and the bank address all come straight from flops. `req_ready` is high exactly when the sequencer is idle. While it is low, whatever appears on the request port has no effect: the job is neither queued nor remembered, so the controller must keep `req_valid` asserted until it sees a handshake. A job is taken on a rising edge where both `req_valid` and `req_ready` are high.

Top module: `ddr_refresh_seq`

## Requirements
- R1: A job is accepted only on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high exactly when `busy` is low. Request inputs presented while busy change no output.
- R2: After reset, the bus carries inhibit (CS# high), `busy` and `done` are low, `req_ready` is high and `cke` is high.
- R3: When exactly one mask bit is set, the cycle after acceptance carries a precharge with A10 low and `ba` equal to the index of that bit (mask bit i selects bank i).
- R4: When two or more mask bits are set, the cycle after acceptance carries a precharge with A10 high and `ba` driven to 0.
- R5: When the mask is zero, there is no precharge, and AUTO REFRESH appears in the cycle after acceptance.
- R6: AUTO REFRESH follows a precharge by exactly the precharge-recovery cycle count, and every cycle in between carries NOP.
- R7: When two refreshes are requested (`req_two_refs` = 1), the second AUTO REFRESH follows the first by exactly the refresh-cycle count, with NOP in between.
- R8: `done` is a single-cycle pulse that appears exactly the refresh-cycle count after the last AUTO REFRESH. In that same cycle the bus returns to inhibit. `busy` is high from the cycle after acceptance up to the cycle before `done`.
- R9: Command pins {CS#, RAS#, CAS#, WE#} take the values inhibit = 1111, NOP = 0111, precharge = 0010 and AUTO REFRESH = 0001. No other pattern is ever driven.
- R10: `cke` stays high in every cycle out of reset.
- R11: Each window in cycles is the picosecond value divided by the clock period, rounded up, and never less than 1 (15000/5000 gives 3, 72000/5000 gives 15).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Refresh job offered |
| req_ready | output | 1 | Sequencer idle, job can be taken |
| req_open_mask | input | NUM_BANKS | One bit per bank that is currently open |
| req_two_refs | input | 1 | 1 requests two back-to-back refreshes, 0 requests one |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse when the bus is released |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| a10 | output | 1 | Address bit 10: all-bank precharge select |
| ba | output | BA_W | Bank address |

## Verification
Two events can coincide on one edge. One is the end of a refresh-cycle window, which either issues the second AUTO REFRESH or raises `done` and returns to idle. The other is a request that appears on the port at that moment. The bench keeps driving random `req_valid`, masks and counts throughout every busy window, including the cycle just before release. It then compares every bus cycle with a trace computed from the job alone, so a stray acceptance shows up at once as a shifted precharge or refresh. Directed jobs cover the zero mask, single banks at both ends of the mask, multi-bank masks and both refresh counts.

// File: rtl/ddr_ref_pkg.sv
package ddr_ref_pkg;

  typedef enum logic [1:0] {
    CMD_INH = 2'd0,
    CMD_NOP = 2'd1,
    CMD_PRE = 2'd2,
    CMD_REF = 2'd3
  } ref_cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_PRE_WAIT = 2'd1,
    ST_RFC_WAIT = 2'd2
  } ref_state_e;

  // round a picosecond window up to whole clocks, at least one
  function automatic int ps_to_cycles(input int win_ps, input int clk_ps);
    int c;
    c = (win_ps + clk_ps - 1) / clk_ps;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/ref_bank_decode.sv
module ref_bank_decode #(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [NUM_BANKS-1:0] open_mask,
  output logic                 any_open,
  output logic                 multi_open,
  output logic [BA_W-1:0]      sel_ba
);

  logic [$clog2(NUM_BANKS+1)-1:0] n_open;

  always_comb begin
    n_open = '0;
    sel_ba = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (open_mask[i]) begin
        n_open = n_open + 1'b1;
        sel_ba = BA_W'(i);
      end
    end
  end

  assign any_open   = (n_open != '0);
  assign multi_open = (n_open > 1);

endmodule

// File: rtl/ref_wait_timer.sv
module ref_wait_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load)            cnt_q <= load_val;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/ref_cmd_pins.sv
module ref_cmd_pins
  import ddr_ref_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ref_cmd_e        cmd,
  input  logic            a10_in,
  input  logic [BA_W-1:0] ba_in,
  output logic            cke,
  output logic            cs_n,
  output logic            ras_n,
  output logic            cas_n,
  output logic            we_n,
  output logic            a10,
  output logic [BA_W-1:0] ba
);

  logic [3:0] pins_n;

  always_comb begin
    unique case (cmd)
      CMD_NOP: pins_n = 4'b0111;
      CMD_PRE: pins_n = 4'b0010;
      CMD_REF: pins_n = 4'b0001;
      default: pins_n = 4'b1111;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= 4'b1111;
      a10 <= 1'b0;
      ba  <= '0;
      cke <= 1'b1;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= pins_n;
      a10 <= (cmd == CMD_PRE) ? a10_in : 1'b0;
      ba  <= (cmd == CMD_PRE) ? ba_in : '0;
      cke <= 1'b1;
    end
  end

endmodule

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq
  import ddr_ref_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int CLK_PS    = 5000,
  parameter int TRP_PS    = 15000,
  parameter int TRFC_PS   = 75000,
  parameter int BA_W      = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [NUM_BANKS-1:0] req_open_mask,
  input  logic                 req_two_refs,
  output logic                 busy,
  output logic                 done,
  output logic                 cke,
  output logic                 cs_n,
  output logic                 ras_n,
  output logic                 cas_n,
  output logic                 we_n,
  output logic                 a10,
  output logic [BA_W-1:0]      ba
);

  localparam int TRP_CYC  = ps_to_cycles(TRP_PS, CLK_PS);
  localparam int TRFC_CYC = ps_to_cycles(TRFC_PS, CLK_PS);
  localparam int MAX_CYC  = (TRFC_CYC > TRP_CYC) ? TRFC_CYC : TRP_CYC;
  localparam int CNT_W    = $clog2(MAX_CYC + 1);

  ref_state_e state_q, state_d;
  logic [1:0] refs_q, refs_d;
  logic       done_q, done_d;

  ref_cmd_e        cmd_d;
  logic            a10_d;
  logic [BA_W-1:0] ba_d;
  logic            t_load;
  logic [CNT_W-1:0] t_val;
  logic            t_expired;

  logic            any_open, multi_open;
  logic [BA_W-1:0] sel_ba;
  logic            accept;

  ref_bank_decode #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_decode (
    .open_mask  (req_open_mask),
    .any_open   (any_open),
    .multi_open (multi_open),
    .sel_ba     (sel_ba)
  );

  ref_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (t_load),
    .load_val (t_val),
    .expired  (t_expired)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d = state_q;
    refs_d  = refs_q;
    done_d  = 1'b0;
    cmd_d   = CMD_NOP;
    a10_d   = 1'b0;
    ba_d    = '0;
    t_load  = 1'b0;
    t_val   = '0;
    unique case (state_q)
      ST_IDLE: begin
        cmd_d = CMD_INH;
        if (accept) begin
          t_load = 1'b1;
          if (any_open) begin
            cmd_d   = CMD_PRE;
            a10_d   = multi_open;
            ba_d    = multi_open ? '0 : sel_ba;
            t_val   = CNT_W'(TRP_CYC - 1);
            refs_d  = req_two_refs ? 2'd2 : 2'd1;
            state_d = ST_PRE_WAIT;
          end else begin
            cmd_d   = CMD_REF;
            t_val   = CNT_W'(TRFC_CYC - 1);
            refs_d  = req_two_refs ? 2'd1 : 2'd0;
            state_d = ST_RFC_WAIT;
          end
        end
      end
      ST_PRE_WAIT: begin
        if (t_expired) begin
          cmd_d   = CMD_REF;
          t_load  = 1'b1;
          t_val   = CNT_W'(TRFC_CYC - 1);
          refs_d  = refs_q - 2'd1;
          state_d = ST_RFC_WAIT;
        end
      end
      ST_RFC_WAIT: begin
        if (t_expired) begin
          if (refs_q != 2'd0) begin
            cmd_d  = CMD_REF;
            t_load = 1'b1;
            t_val  = CNT_W'(TRFC_CYC - 1);
            refs_d = refs_q - 2'd1;
          end else begin
            cmd_d   = CMD_INH;
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end
        end
      end
      default: begin
        cmd_d   = CMD_INH;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      refs_q  <= 2'd0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      refs_q  <= refs_d;
      done_q  <= done_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  ref_cmd_pins #(.BA_W(BA_W)) u_pins (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd    (cmd_d),
    .a10_in (a10_d),
    .ba_in  (ba_d),
    .cke    (cke),
    .cs_n   (cs_n),
    .ras_n  (ras_n),
    .cas_n  (cas_n),
    .we_n   (we_n),
    .a10    (a10),
    .ba     (ba)
  );

endmodule

// File: rtl/ddr_refresh_seq_chk.sv
module ddr_refresh_seq_chk #(
  parameter int TRP_CYC  = 3,
  parameter int TRFC_CYC = 15,
  parameter int BA_W     = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            busy,
  input logic            done,
  input logic            cke,
  input logic            cs_n,
  input logic            ras_n,
  input logic            cas_n,
  input logic            we_n,
  input logic            a10,
  input logic [BA_W-1:0] ba
);

  logic is_pre, is_ref;
  logic [15:0] pre_gap, ref_gap;

  assign is_pre = ({cs_n, ras_n, cas_n, we_n} == 4'b0010);
  assign is_ref = ({cs_n, ras_n, cas_n, we_n} == 4'b0001);

  // cycles since the last observed precharge / refresh, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_gap <= 16'hFFFF;
      ref_gap <= 16'hFFFF;
    end else begin
      pre_gap <= is_pre ? 16'd1 : ((pre_gap == 16'hFFFF) ? pre_gap : pre_gap + 16'd1);
      ref_gap <= is_ref ? 16'd1 : ((ref_gap == 16'hFFFF) ? ref_gap : ref_gap + 16'd1);
    end
  end

  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready != busy);

  assert_all_bank_ba_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_pre && a10) |-> (ba == '0));

  assert_trp_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (pre_gap >= 16'(TRP_CYC)));

  assert_trfc_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (ref_gap >= 16'(TRFC_CYC)));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_rfc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ref_gap == 16'(TRFC_CYC) && !busy && cs_n));

  assert_ref_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref || is_pre) |-> busy);

  assert_legal_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> ({ras_n, cas_n, we_n} == 3'b111 || is_pre || is_ref));

  assert_cke_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cke);

endmodule

bind ddr_refresh_seq ddr_refresh_seq_chk #(
  .TRP_CYC  (TRP_CYC),
  .TRFC_CYC (TRFC_CYC),
  .BA_W     (BA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .busy      (busy),
  .done      (done),
  .cke       (cke),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .a10       (a10),
  .ba        (ba)
);

// File: tb/ddr_refresh_seq_tb.sv
module ddr_refresh_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NB      = 4;
  localparam int BAW     = 2;
  localparam int CLK_PS  = 5000;
  localparam int TRP_PS  = 15000;
  localparam int TRFC_PS = 72000;
  // R11: expected windows, rounded up to whole clocks
  localparam int TRP_E  = 3;
  localparam int TRFC_E = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [NB-1:0] req_open_mask = '0;
  logic req_two_refs = 1'b0;
  logic req_ready, busy, done, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [BAW-1:0] ba;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ddr_refresh_seq #(
    .NUM_BANKS(NB), .CLK_PS(CLK_PS), .TRP_PS(TRP_PS), .TRFC_PS(TRFC_PS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_open_mask(req_open_mask), .req_two_refs(req_two_refs),
    .busy(busy), .done(done), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .a10(a10), .ba(ba)
  );

  // {cs,ras,cas,we}: 0 inhibit, 1 nop, 2 precharge, 3 refresh
  function automatic logic [3:0] pins_of(input int code);
    case (code)
      1: return 4'b0111;
      2: return 4'b0010;
      3: return 4'b0001;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic int popc(input logic [NB-1:0] m);
    int c = 0;
    for (int i = 0; i < NB; i++) if (m[i]) c++;
    return c;
  endfunction

  function automatic logic [BAW-1:0] idx_of(input logic [NB-1:0] m);
    logic [BAW-1:0] r = '0;
    for (int i = 0; i < NB; i++) if (m[i]) r = BAW'(i);
    return r;
  endfunction

  // packed observation: pins(4) a10 ba(2) busy done ready
  function automatic logic [9:0] observe();
    return {cs_n, ras_n, cas_n, we_n, a10, ba, busy, done, req_ready};
  endfunction

  task automatic check(input bit ok, input string req, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_job(input logic [NB-1:0] mask, input bit two, input bit noisy);
    int p, ar0, ar1, dn, code;
    logic [9:0] exp;
    string tag;
    @(negedge clk);
    check(req_ready === 1'b1, "R1", {9'b0, req_ready}, 10'b1);
    req_valid = 1'b1; req_open_mask = mask; req_two_refs = two;
    p   = (mask != '0) ? 1 : 0;
    ar0 = p ? TRP_E : 0;
    ar1 = ar0 + TRFC_E;
    dn  = (two ? ar1 : ar0) + TRFC_E;
    for (int j = 0; j <= dn; j++) begin
      @(negedge clk);
      // R1: while busy, random request traffic must not disturb anything
      req_valid     = (j < dn) ? (noisy ? 1'($urandom % 2) : 1'b0) : 1'b0;
      req_open_mask = NB'($urandom);
      req_two_refs  = 1'($urandom % 2);
      code = 1;
      if (p == 1 && j == 0) code = 2;
      else if (j == ar0 || (two && j == ar1)) code = 3;
      else if (j == dn) code = 0;
      exp[9:6] = pins_of(code);
      exp[5]   = (code == 2) ? (popc(mask) > 1) : 1'b0;
      exp[4:3] = (code == 2 && popc(mask) == 1) ? idx_of(mask) : '0;
      exp[2]   = (j < dn);
      exp[1]   = (j == dn);
      exp[0]   = (j == dn);
      if (code == 2) tag = (popc(mask) > 1) ? "R4" : "R3";
      else if (j == 0) tag = "R5";
      else if (j <= ar0) tag = "R6 R11";
      else if (two && j <= ar1) tag = "R7 R11";
      else if (j == dn) tag = "R8";
      else tag = "R9";
      check(observe() === exp, tag, observe(), exp);
      check(cke === 1'b1, "R10", {9'b0, cke}, 10'b1);
    end
  endtask

  initial begin
    logic [9:0] exp_rst;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    exp_rst = {4'b1111, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1};
    check(observe() === exp_rst && cke === 1'b1, "R2", observe(), exp_rst);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(observe() === exp_rst && cke === 1'b1, "R2", observe(), exp_rst);

    // directed corners
    run_job(4'b0001, 1'b0, 1'b0);   // R3 lowest bank
    run_job(4'b1000, 1'b1, 1'b1);   // R3 highest bank, R7
    run_job(4'b0100, 1'b0, 1'b1);
    run_job(4'b0110, 1'b0, 1'b1);   // R4
    run_job(4'b1111, 1'b1, 1'b1);   // R4, R7
    run_job(4'b0000, 1'b0, 1'b1);   // R5
    run_job(4'b0000, 1'b1, 1'b1);   // R5, R7

    // R1: idle with no valid, nothing moves
    req_valid = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(observe() === exp_rst, "R1", observe(), exp_rst);
    end

    for (int e = 0; e < 40; e++) begin
      run_job(NB'($urandom), 1'($urandom % 2), 1'b1);
      req_valid = 1'b0;
      for (int k = 0; k < int'($urandom % 3); k++) begin
        @(negedge clk);
        check(observe() === exp_rst, "R8", observe(), exp_rst);
      end
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule